// File: doc/BRIEF.md
# Series Compensator Gate Sequencer

This block sequences the four gates of a full-bridge series compensator whose DC capacitor floats in the line. Each bridge switches once per half cycle of line frequency. No carrier or pulse-width modulation is involved. One leg of the sequencer serves one phase, and the top instantiates a leg for each phase of the system. All legs share a minimum capacitor voltage floor and a phase-lag setpoint. Each leg takes its own sampled current phase angle and its own digitized capacitor voltage.

A leg works through three kinds of state:
- One diagonal switch pair conducts and the capacitor charges.
- When the capacitor voltage has fallen to the floor, the leg enters bypass. Bypass closes both switches on one side of the bridge, so the series voltage becomes zero while the capacitor keeps its charge.
- When the current phase sweeps past the lag threshold, the leg leaves bypass for the other diagonal pair.

The threshold is the lag setpoint measured from the 90-degree point of the current. A floor of zero reduces the control to setting only the length of the bypass interval. State moves only on an update strobe, which arrives a fixed number of times per line cycle.

Top module: `sc_gate_seq`

## Requirements
- R1: While reset is high, and after reset until the first update strobe, every gate output is 0 and every mode output is 0 (off).
- R2: The first update after reset puts each leg into bypass (mode 3) with S3 and S4 on. The gate code is 4'b1100, with bit 0 = S1, bit 1 = S2, bit 2 = S3 and bit 3 = S4. No threshold crossing is evaluated on that update.
- R3: The threshold is (lag + 128) mod 512 on the 9-bit phase scale, where 512 counts span one cycle. A crossing occurs when the threshold lies in the half-open range (previous phase, present phase] measured forward modulo 512, and the forward step is below 256. In bypass, a crossing moves the leg to a pair mode on that update.
- R4: Pair modes alternate. The first pair after reset is S1+S3 (4'b0101, mode 1), the next is S2+S4 (4'b1010, mode 2), and so on.
- R5: In a pair mode, once blanking has ended, an update with capacitor voltage less than or equal to the floor moves the leg to bypass (mode 3) on that update.
- R6: The voltage comparison is blanked for the first BLANK updates after a pair entry. A low voltage seen during those updates does not end the pair.
- R7: Bypass after the S1+S3 pair uses S1+S2 (4'b0011). Bypass after the S2+S4 pair uses S3+S4 (4'b1100).
- R8: Without an update strobe, gate and mode outputs hold their values, whatever the other inputs do.
- R9: With a floor of 0, a pair ends only on a voltage reading of exactly 0.
- R10: A threshold at or near phase 0 is crossed when the phase wraps from the top of the scale past 0.
- R11: Legs act independently. A crossing on one phase input moves only that leg.
- R12: In a pair mode, a phase crossing has no effect. Only the voltage condition ends the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | Update strobe, one per control step |
| phase_i | input | NPH*PH_W | Current phase per leg, leg n in bits [n*PH_W +: PH_W] |
| vcap_i | input | NPH*VC_W | Capacitor voltage per leg, leg n in bits [n*VC_W +: VC_W] |
| vmin_i | input | VC_W | Shared capacitor voltage floor |
| lag_i | input | PH_W | Shared phase-lag setpoint, zero at 90 degrees |
| gate_o | output | NPH*4 | Gate enables per leg, bit 0 = S1 … bit 3 = S4 |
| mode_o | output | NPH*2 | Mode per leg: 0 off, 1 S1+S3, 2 S2+S4, 3 bypass |

## Verification
The bench builds the block with three legs, 9-bit phase and 12-bit voltage, and overrides BLANK to 4 updates. With that setting, the full blanking window and the first armed comparison both fall within a few directed steps. The phase steps are spaced so that a full wrap of the scale, a second threshold pass during a pair, and a threshold moved onto zero can each be reached from a known state. A separate scenario drives unequal phases so that one leg crosses while the others stay in bypass.

// File: rtl/sc_gate_pkg.sv
package sc_gate_pkg;
  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_PA  = 2'd1,
    ST_PB  = 2'd2,
    ST_BYP = 2'd3
  } leg_state_e;

  localparam logic [3:0] G_OFF  = 4'b0000;
  localparam logic [3:0] G_PA   = 4'b0101;
  localparam logic [3:0] G_PB   = 4'b1010;
  localparam logic [3:0] G_BYPA = 4'b0011;
  localparam logic [3:0] G_BYPB = 4'b1100;
endpackage

// File: rtl/sc_phase_cross.sv
module sc_phase_cross #(
  parameter int PH_W = 9
) (
  input  logic [PH_W-1:0] prev_i,
  input  logic [PH_W-1:0] cur_i,
  input  logic [PH_W-1:0] lag_i,
  output logic            hit_o
);
  localparam logic [PH_W-1:0] QUARTER = PH_W'(1) << (PH_W - 2);
  localparam logic [PH_W-1:0] HALF    = PH_W'(1) << (PH_W - 1);

  logic [PH_W-1:0] thr;
  logic [PH_W-1:0] d_cur;
  logic [PH_W-1:0] d_thr;

  always_comb begin
    thr   = lag_i + QUARTER;
    d_cur = cur_i - prev_i;
    d_thr = thr - prev_i;
    hit_o = (d_thr != '0) && (d_thr <= d_cur) && (d_cur < HALF);
  end
endmodule

// File: rtl/sc_blank_timer.sv
module sc_blank_timer #(
  parameter int BLANK = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic upd_i,
  input  logic start_i,
  input  logic run_i,
  output logic armed_o
);
  localparam int CNT_W = $clog2(BLANK + 1) + 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BLANK);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      cnt_q <= '0;
    end else if (upd_i && run_i && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign armed_o = (cnt_q == LIMIT);

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);

  p_cnt_restart_r6: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (cnt_q == '0));
endmodule

// File: rtl/sc_phase_leg.sv
module sc_phase_leg
  import sc_gate_pkg::*;
#(
  parameter int PH_W  = 9,
  parameter int VC_W  = 12,
  parameter int BLANK = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic [VC_W-1:0] vcap_i,
  input  logic [VC_W-1:0] vmin_i,
  input  logic [PH_W-1:0] lag_i,
  output logic [3:0]      gate_o,
  output logic [1:0]      mode_o
);
  leg_state_e      st_q;
  logic [3:0]      gate_q;
  logic [PH_W-1:0] prev_q;
  logic            last_b_q;
  logic            hit;
  logic            armed;
  logic            start;
  logic            in_pair;
  logic            low_v;

  sc_phase_cross #(.PH_W(PH_W)) u_cross (
    .prev_i (prev_q),
    .cur_i  (phase_i),
    .lag_i  (lag_i),
    .hit_o  (hit)
  );

  assign in_pair = (st_q == ST_PA) || (st_q == ST_PB);
  assign start   = upd_i && (st_q == ST_BYP) && hit;
  assign low_v   = (vcap_i <= vmin_i);

  sc_blank_timer #(.BLANK(BLANK)) u_blank (
    .clk     (clk),
    .rst     (rst),
    .upd_i   (upd_i),
    .start_i (start),
    .run_i   (in_pair),
    .armed_o (armed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_OFF;
      gate_q   <= G_OFF;
      prev_q   <= '0;
      last_b_q <= 1'b1;
    end else if (upd_i) begin
      prev_q <= phase_i;
      case (st_q)
        ST_OFF: begin
          st_q   <= ST_BYP;
          gate_q <= G_BYPB;
        end
        ST_BYP: begin
          if (hit) begin
            if (last_b_q) begin
              st_q     <= ST_PA;
              gate_q   <= G_PA;
              last_b_q <= 1'b0;
            end else begin
              st_q     <= ST_PB;
              gate_q   <= G_PB;
              last_b_q <= 1'b1;
            end
          end
        end
        default: begin
          if (armed && low_v) begin
            st_q   <= ST_BYP;
            gate_q <= last_b_q ? G_BYPB : G_BYPA;
          end
        end
      endcase
    end
  end

  assign gate_o = gate_q;
  assign mode_o = st_q;

  p_gate_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (gate_q == G_OFF) || (($countones(gate_q) == 2) &&
      (gate_q != 4'b1001) && (gate_q != 4'b0110)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> ($stable(gate_q) && $stable(st_q)));

  p_pair_from_bypass_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_i && (st_q != ST_BYP) && (st_q != ST_OFF)) |=> (st_q != ST_PA || $past(st_q) == ST_PA) && (st_q != ST_PB || $past(st_q) == ST_PB));

  p_bypass_needs_low_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_i && in_pair && !low_v) |=> (st_q != ST_BYP));

  p_never_off_again_r1: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_OFF) |=> (st_q != ST_OFF));
endmodule

// File: rtl/sc_gate_seq.sv
module sc_gate_seq #(
  parameter int NPH   = 3,
  parameter int PH_W  = 9,
  parameter int VC_W  = 12,
  parameter int BLANK = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                upd_i,
  input  logic [NPH*PH_W-1:0] phase_i,
  input  logic [NPH*VC_W-1:0] vcap_i,
  input  logic [VC_W-1:0]     vmin_i,
  input  logic [PH_W-1:0]     lag_i,
  output logic [NPH*4-1:0]    gate_o,
  output logic [NPH*2-1:0]    mode_o
);
  for (genvar n = 0; n < NPH; n++) begin : g_leg
    sc_phase_leg #(
      .PH_W  (PH_W),
      .VC_W  (VC_W),
      .BLANK (BLANK)
    ) u_leg (
      .clk     (clk),
      .rst     (rst),
      .upd_i   (upd_i),
      .phase_i (phase_i[n*PH_W +: PH_W]),
      .vcap_i  (vcap_i[n*VC_W +: VC_W]),
      .vmin_i  (vmin_i),
      .lag_i   (lag_i),
      .gate_o  (gate_o[n*4 +: 4]),
      .mode_o  (mode_o[n*2 +: 2])
    );
  end
endmodule

// File: tb/sc_gate_seq_tb.sv
module sc_gate_seq_tb;
  localparam int NPH = 3;
  localparam int PH_W = 9;
  localparam int VC_W = 12;
  localparam int BLANK = 4;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                upd = 1'b0;
  logic [NPH*PH_W-1:0] phase = '0;
  logic [NPH*VC_W-1:0] vcap = '0;
  logic [VC_W-1:0]     vmin = '0;
  logic [PH_W-1:0]     lag = '0;
  logic [NPH*4-1:0]    gate;
  logic [NPH*2-1:0]    mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sc_gate_seq #(.NPH(NPH), .PH_W(PH_W), .VC_W(VC_W), .BLANK(BLANK)) u_dut (
    .clk (clk), .rst (rst), .upd_i (upd), .phase_i (phase), .vcap_i (vcap),
    .vmin_i (vmin), .lag_i (lag), .gate_o (gate), .mode_o (mode)
  );

  task automatic chk(input string req, input logic [3:0] g, input logic [1:0] m);
    n_chk++;
    if (gate !== {NPH{g}} || mode !== {NPH{m}}) begin
      n_bad++;
      $display("FAIL %s: gate=%h mode=%h expected gate=%h mode=%h", req, gate, mode, {NPH{g}}, {NPH{m}});
    end
  endtask

  task automatic step(input logic [PH_W-1:0] p, input logic [VC_W-1:0] v);
    @(negedge clk);
    phase = {NPH{p}};
    vcap  = {NPH{v}};
    upd   = 1'b1;
    @(negedge clk);
    upd   = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    upd = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_start();
    vmin = 12'd100;
    lag  = 9'd0;
    do_reset();
    chk("R1 after reset", 4'b0000, 2'd0);
    repeat (3) @(negedge clk);
    chk("R1 idle before first update", 4'b0000, 2'd0);
    step(9'd0, 12'd500);
    chk("R2 first update bypass", 4'b1100, 2'd3);
    step(9'd64, 12'd500);
    chk("R3 no crossing below threshold", 4'b1100, 2'd3);
  endtask

  task automatic t_pair_a_blank();
    step(9'd128, 12'd500);
    chk("R3 R4 crossing to first pair", 4'b0101, 2'd1);
    for (int i = 0; i < BLANK; i++) begin
      step(9'(130 + i), 12'd50);
      chk("R6 low voltage blanked", 4'b0101, 2'd1);
    end
    step(9'd140, 12'd50);
    chk("R5 R7 bypass after first pair", 4'b0011, 2'd3);
  endtask

  task automatic t_hold();
    @(negedge clk);
    phase = {NPH{9'd300}};
    vcap  = '0;
    lag   = 9'd200;
    repeat (4) @(negedge clk);
    chk("R8 no strobe holds outputs", 4'b0011, 2'd3);
    lag = 9'd0;
  endtask

  task automatic t_pair_b();
    step(9'd192, 12'd500);
    step(9'd256, 12'd500);
    step(9'd320, 12'd500);
    step(9'd384, 12'd500);
    step(9'd448, 12'd500);
    step(9'd0, 12'd500);
    step(9'd64, 12'd500);
    chk("R3 still bypass before threshold", 4'b0011, 2'd3);
    step(9'd128, 12'd500);
    chk("R4 second pair alternates", 4'b1010, 2'd2);
    step(9'd160, 12'd200);
    step(9'd192, 12'd200);
    step(9'd224, 12'd200);
    step(9'd256, 12'd200);
    step(9'd300, 12'd150);
    chk("R5 voltage above floor keeps pair", 4'b1010, 2'd2);
    step(9'd400, 12'd150);
    step(9'd500, 12'd150);
    step(9'd100, 12'd150);
    step(9'd130, 12'd150);
    chk("R12 crossing ignored in pair", 4'b1010, 2'd2);
    step(9'd140, 12'd100);
    chk("R5 R7 equal to floor enters bypass", 4'b1100, 2'd3);
  endtask

  task automatic t_wrap_and_zero_floor();
    lag  = 9'd384;
    vmin = 12'd0;
    step(9'd300, 12'd500);
    step(9'd500, 12'd500);
    chk("R10 no crossing before wrap", 4'b1100, 2'd3);
    step(9'd4, 12'd500);
    chk("R10 wrap crossing enters pair", 4'b0101, 2'd1);
    for (int i = 0; i < BLANK; i++) step(9'(8 + i), 12'd0);
    step(9'd20, 12'd1);
    chk("R9 nonzero voltage with zero floor keeps pair", 4'b0101, 2'd1);
    step(9'd24, 12'd0);
    chk("R9 zero voltage with zero floor bypass", 4'b0011, 2'd3);
  endtask

  task automatic t_independent();
    vmin = 12'd100;
    lag  = 9'd0;
    do_reset();
    step(9'd100, 12'd500);
    @(negedge clk);
    phase = {9'd10, 9'd130, 9'd10};
    upd   = 1'b1;
    @(negedge clk);
    upd   = 1'b0;
    n_chk++;
    if (gate !== 12'hC5C || mode !== 6'b110111) begin
      n_bad++;
      $display("FAIL R11: gate=%h mode=%b expected gate=c5c mode=110111", gate, mode);
    end
  endtask

  initial begin
    t_reset_start();
    t_pair_a_blank();
    t_hold();
    t_pair_b();
    t_wrap_and_zero_floor();
    t_independent();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule